// File: doc/BRIEF.md
# Sixteen-Bit Watchdog Timer with Byte Self-Test

The block is a watchdog for a small microcontroller. A 16-bit counter advances on every bus clock while the watchdog runs. When it reaches the programmed timeout it either requests a chip reset at once, or it raises an interrupt first and requests the reset 128 clocks later. Software keeps the counter away from the timeout by writing a two-word refresh key to the count register. Any wrong word in that register requests a reset straight away.

Configuration is write-once. After any reset there is a 128-clock window in which the control and timeout registers accept writes. The window also closes at the first control write. If the update-permission bit was set, writing a two-word unlock key opens a new 128-clock window for reconfiguration. A two-bit test field selects normal compare, or a fast self-test that compares only one byte of the counter. Only power-on reset clears this field; a system reset leaves it as it was. Three run-enable bits decide whether counting goes on while the chip is in debug, wait or stop mode.

Register map (word addresses): 0 is control, 1 is count (writes are keys, reads return the counter), 2 is timeout, 3 reads the window-open status in bit 0. Control bits: [0] enable, [1] interrupt enable, [2] update permission, [4:3] test field, [5] debug run, [6] wait run, [7] stop run, [8] interrupt flag (write 1 to clear). Keys: refresh 16'h6E17 then 16'h17E6; unlock 16'h5A3C then 16'hC3A5.

Top module: `wdt16`

## Requirements
- R1: After power-on reset, control reads 16'h0001, timeout reads 16'h0400, status reads 1, and `irq` and `rst_req` are low.
- R2: With interrupt enable clear, `rst_req` rises on the clock edge after the counter equals the timeout, and `irq` stays low.
- R3: With interrupt enable set, `irq` rises on the edge after the counter equals the timeout, and `rst_req` rises 128 clocks after that. Writing 1 to control bit 8 drops `irq`, but the reset still follows.
- R4: Writing 16'h6E17 and then 16'h17E6 to the count register clears the counter. Between writes the counter only holds, adds one, or clears.
- R5: Any count-register write that breaks the key sequences raises `rst_req` on that edge, and it stays high until reset.
- R6: Control and timeout writes take effect only while the window is open. The window lasts 128 clocks after reset and closes at the first control write. Otherwise these writes are ignored, apart from the flag clear.
- R7: With update permission set, writing 16'h5A3C and then 16'hC3A5 to the count register reopens the window and allows reconfiguration. With the permission clear, the window stays shut.
- R8: A reopened window closes exactly 128 clocks after the unlock edge, or at the next count-register write.
- R9: Test field 2'b10 times out when the counter low byte equals the timeout low byte. 2'b11 compares the high bytes only. 2'b00 and 2'b01 compare all 16 bits.
- R10: The test field keeps its value through a system reset. Once written, it cannot change until power-on reset, which clears it to 2'b00.
- R11: While `dbg_mode`, `wait_mode` or `stop_mode` is high and the matching run bit is clear, the counter holds. With the run bit set, it keeps counting.
- R12: With the enable bit clear, the counter holds and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | System reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| dbg_mode | input | 1 | Chip is in debug mode |
| wait_mode | input | 1 | Chip is in wait mode |
| stop_mode | input | 1 | Chip is in stop mode |
| irq | output | 1 | Timeout interrupt |
| rst_req | output | 1 | Reset request, held until reset |

## Verification
Most internal faults reach `rst_req` within a few cycles. A broken key-sequence tracker turns a valid refresh into a reset on the second write. A wrong compare selection moves the timeout edge by hundreds of cycles under the byte test modes. A miscounted delay moves the reset away from exactly 128 clocks after `irq`. Faults in the window, the lock or the test field show up at once in register readback: the status bit, or a timeout or control value that did or did not change after a write.

// File: rtl/wdt16.sv
module wdt16 #(
  parameter int CW = 16,
  parameter int WIN = 128,
  parameter int DLY = 128,
  parameter logic [CW-1:0] TOV_RST = 16'h0400,
  parameter logic [CW-1:0] REF1 = 16'h6E17,
  parameter logic [CW-1:0] REF2 = 16'h17E6,
  parameter logic [CW-1:0] UNL1 = 16'h5A3C,
  parameter logic [CW-1:0] UNL2 = 16'hC3A5
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  input  logic          dbg_mode,
  input  logic          wait_mode,
  input  logic          stop_mode,
  output logic          irq,
  output logic          rst_req
);
  localparam int WW = $clog2(WIN);
  localparam int DW = $clog2(DLY);
  localparam int HB = CW / 2;

  logic sys_n;
  logic en, ie, upd, den, wen, sen, flag;
  logic [1:0] tst;
  logic tst_lk;
  logic [CW-1:0] cnt, tov;
  logic open;
  logic [WW-1:0] wcnt;
  logic rp, up, expd, dly_on;
  logic [DW-1:0] dcnt;

  assign sys_n = por_n & rst_n;

  wire wc = wr_en && (wr_addr == 2'd0);
  wire wk = wr_en && (wr_addr == 2'd1);
  wire wt = wr_en && (wr_addr == 2'd2);

  wire run = en & ~(dbg_mode & ~den) & ~(wait_mode & ~wen) & ~(stop_mode & ~sen);
  wire hit = (tst == 2'b10) ? (cnt[HB-1:0] == tov[HB-1:0]) :
             (tst == 2'b11) ? (cnt[CW-1:HB] == tov[CW-1:HB]) :
                              (cnt == tov);
  wire fire = en & hit & ~expd;

  wire ref_ok = wk & rp & (wr_data == REF2);
  wire unl_ok = wk & up & (wr_data == UNL2);
  wire bad = wk & (rp ? (wr_data != REF2) :
                   up ? (wr_data != UNL2) :
                        ((wr_data != REF1) && (wr_data != UNL1)));

  always_ff @(posedge clk or negedge sys_n) begin
    if (!sys_n) begin
      en <= 1'b1; ie <= 1'b0; upd <= 1'b0;
      den <= 1'b0; wen <= 1'b0; sen <= 1'b0;
      tov <= TOV_RST;
      flag <= 1'b0;
    end else begin
      if (wc && open) begin
        en  <= wr_data[0];
        ie  <= wr_data[1];
        upd <= wr_data[2];
        den <= wr_data[5];
        wen <= wr_data[6];
        sen <= wr_data[7];
      end
      if (wt && open) tov <= wr_data;
      if (fire && ie) flag <= 1'b1;
      else if (wc && wr_data[8]) flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      tst <= 2'b00;
      tst_lk <= 1'b0;
    end else if (wc && open && !tst_lk) begin
      tst <= wr_data[4:3];
      tst_lk <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge sys_n) begin
    if (!sys_n) begin
      open <= 1'b1;
      wcnt <= WW'(WIN - 1);
    end else if (unl_ok && upd) begin
      open <= 1'b1;
      wcnt <= WW'(WIN - 1);
    end else if (wc || wk) begin
      open <= 1'b0;
    end else if (open) begin
      if (wcnt == '0) open <= 1'b0;
      else wcnt <= wcnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge sys_n) begin
    if (!sys_n) begin
      rp <= 1'b0;
      up <= 1'b0;
    end else if (wk) begin
      rp <= ~rp & ~up & (wr_data == REF1);
      up <= ~rp & ~up & (wr_data == UNL1);
    end
  end

  always_ff @(posedge clk or negedge sys_n) begin
    if (!sys_n) begin
      cnt <= '0;
      expd <= 1'b0;
    end else begin
      if (ref_ok) cnt <= '0;
      else if (run) cnt <= cnt + 1'b1;
      if (fire) expd <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge sys_n) begin
    if (!sys_n) begin
      dly_on <= 1'b0;
      dcnt <= '0;
    end else if (fire && ie) begin
      dly_on <= 1'b1;
      dcnt <= '0;
    end else if (dly_on) begin
      dcnt <= dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge sys_n) begin
    if (!sys_n) rst_req <= 1'b0;
    else if (bad || (fire && !ie) || (dly_on && dcnt == DW'(DLY - 1))) rst_req <= 1'b1;
  end

  assign irq = flag & ie;

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {{(CW-9){1'b0}}, flag, sen, wen, den, tst, upd, ie, en};
      2'd1:    rd_data = cnt;
      2'd2:    rd_data = tov;
      default: rd_data = {{(CW-1){1'b0}}, open};
    endcase
  end
endmodule

// File: rtl/wdt16_chk.sv
module wdt16_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          sys_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic          dbg_mode,
  input logic          den,
  input logic          open,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] tov,
  input logic          rst_req
);
  wire kw = wr_en && (wr_addr == 2'd1);

  AST_RST_HELD: assert property (@(posedge clk) disable iff (!sys_n)
    rst_req |=> rst_req); // R5
  AST_DBG_FREEZE: assert property (@(posedge clk) disable iff (!sys_n)
    (dbg_mode && !den && !kw) |=> (cnt == $past(cnt))); // R11
  AST_WIN_NO_REOPEN: assert property (@(posedge clk) disable iff (!sys_n)
    (!open && !kw) |=> !open); // R8
  AST_TOV_FROZEN: assert property (@(posedge clk) disable iff (!sys_n)
    !open |=> (tov == $past(tov))); // R6
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!sys_n)
    1'b1 |=> (cnt == $past(cnt) || cnt == $past(cnt) + CW'(1) || cnt == '0)); // R4
endmodule

bind wdt16 wdt16_chk #(.CW(CW)) u_chk (
  .clk(clk), .sys_n(sys_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .dbg_mode(dbg_mode), .den(den), .open(open), .cnt(cnt), .tov(tov),
  .rst_req(rst_req)
);

// File: tb/wdt16_tb.sv
module wdt16_tb;
  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
  logic [15:0] wr_data = 16'h0, rd_data;
  logic dbg_mode = 1'b0, wait_mode = 1'b0, stop_mode = 1'b0;
  logic irq, rst_req;
  int n_chk = 0, n_bad = 0;

  localparam logic [15:0] REF1 = 16'h6E17, REF2 = 16'h17E6;
  localparam logic [15:0] UNL1 = 16'h5A3C, UNL2 = 16'hC3A5;

  wdt16 u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .dbg_mode(dbg_mode),
    .wait_mode(wait_mode), .stop_mode(stop_mode), .irq(irq), .rst_req(rst_req)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic por();
    @(negedge clk);
    por_n = 1'b0; rst_n = 1'b0; wr_en = 1'b0;
    dbg_mode = 1'b0; wait_mode = 1'b0; stop_mode = 1'b0;
    tick(2);
    por_n = 1'b1; rst_n = 1'b1;
  endtask

  task automatic refresh();
    wr(2'd1, REF1);
    wr(2'd1, REF2);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    por();
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0001);
    rd(2'd2, v); chk("R1 tov", v, 16'h0400);
    rd(2'd3, v); chk("R1 window", v, 16'h0001);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    chk("R1 rst_req", {15'h0, rst_req}, 16'h0);
  endtask

  task automatic t_plain_timeout();
    por();
    wr(2'd2, 16'd20);
    wr(2'd0, 16'h0001);
    refresh();
    tick(20);
    chk("R2 no early reset", {15'h0, rst_req}, 16'h0);
    tick(1);
    chk("R2 reset on timeout", {15'h0, rst_req}, 16'h1);
    chk("R2 irq stays low", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_irq_delay();
    por();
    wr(2'd2, 16'd20);
    wr(2'd0, 16'h0003);
    refresh();
    tick(20);
    chk("R3 no early irq", {15'h0, irq}, 16'h0);
    tick(1);
    chk("R3 irq at timeout", {15'h0, irq}, 16'h1);
    chk("R3 reset delayed", {15'h0, rst_req}, 16'h0);
    tick(9);
    wr(2'd0, 16'h0100);
    chk("R3 flag cleared", {15'h0, irq}, 16'h0);
    tick(117);
    chk("R3 reset not before 128", {15'h0, rst_req}, 16'h0);
    tick(1);
    chk("R3 reset after 128", {15'h0, rst_req}, 16'h1);
  endtask

  task automatic t_refresh();
    logic [15:0] v;
    por();
    wr(2'd0, 16'h0001);
    tick(30);
    rd(2'd1, v);
    chk("R4 counting", {15'h0, (v > 16'd20)}, 16'h1);
    refresh();
    rd(2'd1, v); chk("R4 cleared", v, 16'h0);
    chk("R4 no reset", {15'h0, rst_req}, 16'h0);
  endtask

  task automatic t_bad_key();
    por();
    wr(2'd0, 16'h0001);
    wr(2'd1, REF1);
    wr(2'd1, 16'h1234);
    chk("R5 wrong second word", {15'h0, rst_req}, 16'h1);
    tick(5);
    chk("R5 held", {15'h0, rst_req}, 16'h1);
    por();
    wr(2'd1, 16'h0000);
    chk("R5 stray word", {15'h0, rst_req}, 16'h1);
  endtask

  task automatic t_window();
    logic [15:0] v;
    por();
    tick(130);
    rd(2'd3, v); chk("R6 window expired", v, 16'h0);
    wr(2'd2, 16'h0055);
    rd(2'd2, v); chk("R6 tov ignored", v, 16'h0400);
    wr(2'd0, 16'h00FF);
    rd(2'd0, v); chk("R6 ctrl ignored", v, 16'h0001);
    por();
    wr(2'd0, 16'h0003);
    wr(2'd2, 16'h0077);
    rd(2'd2, v); chk("R6 closed by ctrl write", v, 16'h0400);
  endtask

  task automatic t_unlock();
    logic [15:0] v;
    por();
    wr(2'd0, 16'h0005);
    rd(2'd3, v); chk("R7 shut before unlock", v, 16'h0);
    wr(2'd1, UNL1);
    wr(2'd1, UNL2);
    rd(2'd3, v); chk("R7 reopened", v, 16'h1);
    wr(2'd2, 16'h0099);
    rd(2'd2, v); chk("R7 tov rewritten", v, 16'h0099);
    wr(2'd0, 16'h0003);
    rd(2'd0, v); chk("R7 ctrl rewritten", v, 16'h0003);
    por();
    wr(2'd0, 16'h0001);
    wr(2'd1, UNL1);
    wr(2'd1, UNL2);
    rd(2'd3, v); chk("R7 no permission", v, 16'h0);
    chk("R7 no reset", {15'h0, rst_req}, 16'h0);
  endtask

  task automatic t_window_close();
    logic [15:0] v;
    por();
    wr(2'd0, 16'h0005);
    wr(2'd1, UNL1);
    wr(2'd1, UNL2);
    tick(127);
    rd(2'd3, v); chk("R8 open at 127", v, 16'h1);
    tick(1);
    rd(2'd3, v); chk("R8 shut at 128", v, 16'h0);
    wr(2'd1, UNL1);
    wr(2'd1, UNL2);
    wr(2'd1, REF1);
    rd(2'd3, v); chk("R8 shut by count write", v, 16'h0);
    wr(2'd1, REF2);
  endtask

  task automatic t_test_modes();
    por();
    wr(2'd2, 16'h0305);
    wr(2'd0, 16'h0011);
    refresh();
    tick(5);
    chk("R9 low byte early", {15'h0, rst_req}, 16'h0);
    tick(1);
    chk("R9 low byte hit", {15'h0, rst_req}, 16'h1);
    por();
    wr(2'd2, 16'h0305);
    wr(2'd0, 16'h0019);
    refresh();
    tick(768);
    chk("R9 high byte early", {15'h0, rst_req}, 16'h0);
    tick(1);
    chk("R9 high byte hit", {15'h0, rst_req}, 16'h1);
    por();
    wr(2'd2, 16'h0305);
    wr(2'd0, 16'h0009);
    refresh();
    tick(773);
    chk("R9 full early", {15'h0, rst_req}, 16'h0);
    tick(1);
    chk("R9 full hit", {15'h0, rst_req}, 16'h1);
  endtask

  task automatic t_test_field();
    logic [15:0] v;
    por();
    wr(2'd0, 16'h0011);
    @(negedge clk); rst_n = 1'b0;
    tick(2); rst_n = 1'b1;
    rd(2'd0, v); chk("R10 kept over system reset", v, 16'h0011);
    wr(2'd0, 16'h0019);
    rd(2'd0, v); chk("R10 write-once", v, 16'h0011);
    por();
    rd(2'd0, v); chk("R10 cleared by power-on", v, 16'h0001);
  endtask

  task automatic t_modes();
    logic [15:0] a, b;
    por();
    wr(2'd0, 16'h0001);
    dbg_mode = 1'b1;
    rd(2'd1, a); tick(10); rd(2'd1, b);
    chk("R11 debug hold", b, a);
    dbg_mode = 1'b0; wait_mode = 1'b1;
    rd(2'd1, a); tick(10); rd(2'd1, b);
    chk("R11 wait hold", b, a);
    wait_mode = 1'b0; stop_mode = 1'b1;
    rd(2'd1, a); tick(10); rd(2'd1, b);
    chk("R11 stop hold", b, a);
    por();
    wr(2'd0, 16'h00E1);
    dbg_mode = 1'b1;
    rd(2'd1, a); tick(10); rd(2'd1, b);
    chk("R11 debug runs", b, a + 16'd10);
    dbg_mode = 1'b0; stop_mode = 1'b1;
    rd(2'd1, a); tick(10); rd(2'd1, b);
    chk("R11 stop runs", b, a + 16'd10);
    stop_mode = 1'b0;
  endtask

  task automatic t_disable();
    logic [15:0] a, b;
    por();
    wr(2'd2, 16'd10);
    wr(2'd0, 16'h0000);
    rd(2'd1, a); tick(40); rd(2'd1, b);
    chk("R12 held when off", b, a);
    chk("R12 no reset when off", {15'h0, rst_req}, 16'h0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_plain_timeout();
    t_irq_delay();
    t_refresh();
    t_bad_key();
    t_window();
    t_unlock();
    t_window_close();
    t_test_modes();
    t_test_field();
    t_modes();
    t_disable();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule